// File: doc/BRIEF.md
# SPI Shift Engine

This block is a master-side serial transfer engine. It accepts one transmit word at a time over a valid/ready handshake. It shifts a programmable number of bits out on MOSI and samples the same number of bits in from MISO. A bit clock generated from a reload counter paces each transfer. Clock polarity, clock phase, character length, justification of the transmit bits, the slave-select level and a master enable are plain configuration inputs.

Transmit flow control works as follows. `tx_ready` is high only while the engine is enabled and idle. A word transfers on the rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_data` needs to be valid only in that cycle. While a character is in flight, `tx_valid` exerts no back-pressure and has no effect; a source simply holds its word until `tx_ready` returns. The received character and a completion interrupt appear together at the end of each transfer.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `busy`, `irq` and `rx_data` are 0, `sclk` equals `cpol`, and with `enable` low `ssel` is 1 and `tx_ready` is 0.
- R2: `len_code` values 1 to 15 give characters of that many bits, and code 0 gives 16 bits. A character of N bits makes exactly 2N transitions on `sclk`.
- R3: Bits are sent most significant first. With `left_just` = 0 the character is bits N-1..0 of `tx_data`; with `left_just` = 1 it is bits 15..16-N.
- R4: Each `sclk` half-period lasts H = `reload` clock cycles, with any reload below 2 treated as 2. `busy` stays high for exactly 2·N·H cycles, starting the cycle after acceptance.
- R5: While idle, `sclk` sits at the level of `cpol` (0 = low, 1 = high).
- R6: With `cpha` = 0, MISO is sampled on leading `sclk` edges and MOSI changes on trailing edges. With `cpha` = 1, MOSI changes on leading edges after the first and MISO is sampled on trailing edges.
- R7: The received bits appear right-aligned in `rx_data` (first received bit at position N-1, upper bits 0). `rx_data` changes only in the cycle where `busy` falls.
- R8: `tx_ready` = `enable` and not `busy`. A `tx_valid` seen while the engine is disabled or busy starts nothing and does not alter the character in flight.
- R9: `irq` is set when a character completes, but only if `irq_en` is high at that moment. It stays set until a cycle with `irq_clr` high, and it is never set with `irq_en` low.
- R10: While enabled, `ssel` follows `ssel_val`; while disabled, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable for transfers and slave select |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Sampling edge select |
| len_code | input | 4 | Character length code, 0 means 16 bits |
| left_just | input | 1 | Take transmit bits from the top of the word |
| reload | input | 16 | Half-period of sclk in clock cycles (minimum 2) |
| ssel_val | input | 1 | Level driven on ssel while enabled |
| irq_en | input | 1 | Allows completion to raise irq |
| irq_clr | input | 1 | Clears irq |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can take a word |
| tx_data | input | 16 | Transmit word |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 1 | Slave select |
| rx_data | output | 16 | Last received character, right-aligned |
| busy | output | 1 | Character in progress |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
For a word accepted at rising edge A, `busy` is high from A+1. The k-th `sclk` transition lands at A+k·H. `busy` falls and `rx_data` and `irq` update together at A+2·N·H. The bench drives and samples on the falling edge. It counts the falling edges on which `busy` reads high, so the count is exactly 2·N·H. It reads `rx_data`, `irq` and the idle `sclk` on the first falling edge after `busy` drops. A serial monitor samples on rising edges, so it sees each `sclk` transition one cycle late, before MOSI can move again. For that reason, the bench waits one further cycle before it compares the captured bit stream and the edge count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic {
    XFER_IDLE = 1'b0,
    XFER_RUN  = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt_q;

  assign eff_div = (reload < MIN_DIV) ? MIN_DIV : reload;
  assign tick    = run && !restart && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MIN_DIV;
    end else if (restart) begin
      cnt_q <= eff_div;
    end else if (run) begin
      cnt_q <= (cnt_q == ONE) ? eff_div : cnt_q - ONE;
    end
  end

  // cycles since the last tick or restart, for the spacing check
  logic [DIV_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (restart || tick)  gap_q <= '0;
    else if (run && gap_q != '1) gap_q <= gap_q + ONE;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q >= ONE));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpha,
  input  logic              left_just,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              mosi,
  output logic              sclk_ph,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned NB_W = LEN_W + 1;
  localparam int unsigned EC_W = LEN_W + 2;

  xfer_state_e       state_q;
  logic              cpha_q;
  logic [NB_W-1:0]   nbits_q;
  logic [EC_W-1:0]   edge_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] rx_word_q;
  logic              mosi_q;
  logic              ph_q;

  logic [NB_W-1:0]   nbits_w;
  logic [DATA_W-1:0] aligned;
  logic              last_edge;
  logic              sample_now;
  logic              drive_now;
  logic [DATA_W-1:0] rx_next;

  assign nbits_w    = (len_code == '0) ? NB_W'(DATA_W) : {1'b0, len_code};
  assign aligned    = left_just ? tx_data : (tx_data << (NB_W'(DATA_W) - nbits_w));
  assign busy       = (state_q == XFER_RUN);
  assign last_edge  = (edge_q == ({nbits_q, 1'b0} - 1'b1));
  assign sample_now = busy && tick && (edge_q[0] == cpha_q);
  assign drive_now  = busy && tick && (edge_q[0] != cpha_q) && (edge_q != '0);
  assign rx_next    = sample_now ? {rx_sh_q[DATA_W-2:0], miso} : rx_sh_q;
  assign done       = busy && tick && last_edge;

  assign mosi    = mosi_q;
  assign sclk_ph = ph_q;
  assign rx_word = rx_word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= XFER_IDLE;
      cpha_q    <= 1'b0;
      nbits_q   <= '0;
      edge_q    <= '0;
      sh_q      <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      mosi_q    <= 1'b0;
      ph_q      <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        state_q <= XFER_RUN;
        cpha_q  <= cpha;
        nbits_q <= nbits_w;
        edge_q  <= '0;
        sh_q    <= aligned << 1;
        mosi_q  <= aligned[DATA_W-1];
        rx_sh_q <= '0;
        ph_q    <= 1'b0;
      end
    end else if (tick) begin
      ph_q    <= ~ph_q;
      edge_q  <= edge_q + 1'b1;
      rx_sh_q <= rx_next;
      if (drive_now) begin
        mosi_q <= sh_q[DATA_W-1];
        sh_q   <= sh_q << 1;
      end
      if (last_edge) begin
        state_q   <= XFER_IDLE;
        rx_word_q <= rx_next;
      end
    end
  end

  // R2
  even_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sclk_ph);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> $fell(busy));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cpol,
  input  logic        cpha,
  input  logic [3:0]  len_code,
  input  logic        left_just,
  input  logic [15:0] reload,
  input  logic        ssel_val,
  input  logic        irq_en,
  input  logic        irq_clr,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [15:0] tx_data,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ssel,
  output logic [15:0] rx_data,
  output logic        busy,
  output logic        irq
);

  localparam int unsigned DATA_W = 16;
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned DIV_W  = 16;

  logic accept;
  logic tick;
  logic done;
  logic ph;
  logic busy_w;
  logic irq_q;

  assign tx_ready = enable && !busy_w;
  assign accept   = tx_valid && tx_ready;
  assign sclk     = ph ^ cpol;
  assign ssel     = enable ? ssel_val : 1'b1;
  assign busy     = busy_w;
  assign irq      = irq_q;

  spi_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy_w),
    .reload  (reload),
    .tick    (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cpha      (cpha),
    .left_just (left_just),
    .len_code  (len_code),
    .tx_data   (tx_data),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy_w),
    .mosi      (mosi),
    .sclk_ph   (ph),
    .done      (done),
    .rx_word   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               irq_q <= 1'b0;
    else if (done && irq_en)  irq_q <= 1'b1;
    else if (irq_clr)         irq_q <= 1'b0;
  end

  // R8
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid && enable));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($fell(busy) && $past(irq_en)));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [3:0]  len_code = 4'd8;
  logic        left_just = 1'b0;
  logic [15:0] reload = 16'd2;
  logic        ssel_val = 1'b1;
  logic        irq_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0000;
  logic        inv_q = 1'b0;
  logic        tx_ready, sclk, mosi, miso, ssel, busy, irq;
  logic [15:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign miso = mosi ^ inv_q;

  spi_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .len_code(len_code), .left_just(left_just), .reload(reload),
    .ssel_val(ssel_val), .irq_en(irq_en), .irq_clr(irq_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssel(ssel),
    .rx_data(rx_data), .busy(busy), .irq(irq)
  );

  // {cpol, cpha, left_just, len_code[3:0], reload[15:0], tx_data[15:0], invert}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd8,  16'd2, 16'h00A5, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd8,  16'd3, 16'h003C, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'd4,  16'd2, 16'hFFF9, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd4,  16'd2, 16'hB000, 1'b0},
    {1'b0, 1'b0, 1'b0, 4'd0,  16'd2, 16'hC3A5, 1'b0},
    {1'b0, 1'b1, 1'b1, 4'd0,  16'd4, 16'h8001, 1'b1},
    {1'b1, 1'b1, 1'b0, 4'd1,  16'd5, 16'h0001, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd12, 16'd0, 16'h9ABC, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd15, 16'd1, 16'h7FFE, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'd7,  16'd3, 16'hFE00, 1'b1}
  };

  // serial monitor: sees sclk transitions one cycle after they occur
  bit          mon_arm = 0;
  int          mon_edges = 0;
  logic [31:0] mon_bits = 0;
  logic        sclk_prev = 1'b0;

  always @(posedge clk) begin
    if (mon_arm && sclk !== sclk_prev) begin
      mon_edges <= mon_edges + 1;
      if (((sclk != cpol) && !cpha) || ((sclk == cpol) && cpha))
        mon_bits <= {mon_bits[30:0], mosi};
    end
    sclk_prev <= sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_vec(input logic [39:0] v, input bit ien, input bit poke);
    int n, h, bcnt;
    logic [31:0] bits, mask, rx_exp;
    @(negedge clk);
    cpol = v[39]; cpha = v[38]; left_just = v[37]; len_code = v[36:33];
    reload = v[32:17]; inv_q = v[0]; irq_en = ien;
    n = (v[36:33] == 4'd0) ? 16 : int'(v[36:33]);
    h = (v[32:17] < 16'd2) ? 2 : int'(v[32:17]);
    mask = (32'd1 << n) - 32'd1;
    bits = v[37] ? (32'(v[16:1]) >> (16 - n)) : (32'(v[16:1]) & mask);
    rx_exp = v[0] ? (~bits & mask) : bits;
    @(negedge clk);
    mon_edges = 0; mon_bits = 0; mon_arm = 1;
    tx_data = v[16:1]; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (poke) begin tx_valid = 1'b1; tx_data = 16'h0000; end
    bcnt = 0;
    while (busy === 1'b1 && bcnt < 5000) begin
      bcnt++;
      if (poke && bcnt == 3) tx_valid = 1'b0;
      @(negedge clk);
    end
    chk("R4 busy length", bcnt, 2 * n * h);
    chk("R7 rx_data right-aligned", rx_data, rx_exp);
    chk("R9 irq at completion", irq, ien);
    chk("R5 idle sclk level", sclk, cpol);
    @(negedge clk);
    mon_arm = 0;
    chk("R2 sclk transitions", mon_edges, 2 * n);
    chk("R3 R6 serial bit order", mon_bits, bits);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 irq cleared", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rx_data", rx_data, 16'h0000);
    chk("R1 sclk", sclk, 1'b0);
    chk("R1 ssel", ssel, 1'b1);
    chk("R1 tx_ready", tx_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: disabled engine ignores a valid word
    tx_valid = 1'b1; tx_data = 16'h00FF;
    repeat (3) @(negedge clk);
    chk("R8 disabled no start", busy, 1'b0);
    tx_valid = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    chk("R8 ready when enabled", tx_ready, 1'b1);
    // R10 slave select follows its value
    ssel_val = 1'b0;
    @(negedge clk);
    chk("R10 ssel low", ssel, 1'b0);
    ssel_val = 1'b1;
    @(negedge clk);
    chk("R10 ssel high", ssel, 1'b1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b1, 1'b0);

    // R9: completion with irq_en low leaves irq clear
    run_vec(VEC[0], 1'b0, 1'b0);
    // R8: valid offered mid-transfer does not disturb the character
    run_vec(VEC[4], 1'b1, 1'b1);
    chk("R8 no restart after poke", busy, 1'b0);
    // R10 disabled forces ssel high
    ssel_val = 1'b0; enable = 1'b0;
    @(negedge clk);
    chk("R10 disabled ssel", ssel, 1'b1);
    chk("R8 ready low when disabled", tx_ready, 1'b0);
    finish_run();
  end

endmodule